// File: doc/BRIEF.md
# Cycle-Locked Address Holder with Bank Decode

This block keeps the address of a core memory access steady for the whole cycle. Between cycles it follows the 16-bit address bus. On each clock edge it copies the bus into a holding register, so the downstream select logic always sees the latest address. A cycle-start request sets a lock flag. From the following edge on, the holding register keeps its value, and bus activity cannot move the selected location. An active-low cycle-end strobe clears the lock, and the holder then follows the bus again.

The held address is presented as three fields. The low seven bits select an X line. The next six bits select a Y line. The top three bits pick one of eight banks through a one-hot decode. The decode is gated by a memory-select input. A separate strobe input edge-captures address bit 6 into its own flag, independent of the lock.

Top module: `addr_hold_unit`

## Requirements
- R1: `x_sel_o` equals bits [6:0] of the held address.
- R2: `y_sel_o` equals bits [12:7] of the held address.
- R3: While `mem_sel_i` is high, `bank_o` is one-hot with bit k set, where k is the value of bits [15:13] of the held address (bank_o[0] for 3'b000 up to bank_o[7] for 3'b111).
- R4: While `mem_sel_i` is low, every bit of `bank_o` is 0, whatever the held address is.
- R5: While the lock is clear, every rising clock edge loads `addr_i` into the held address, and the new value is visible on the outputs after that edge.
- R6: A rising edge with `cycle_start_i` high sets the lock. The address sampled on that same edge is kept. Changes on `addr_i` on later edges have no effect on `x_sel_o`, `y_sel_o` or `bank_o` while the lock is set.
- R7: A rising edge with `cycle_end_ni` low clears the lock, and this takes priority over `cycle_start_i`. That edge does not load the bus if the lock was set before it. The next edge loads `addr_i` again.
- R8: On a rising edge where `xstb_i` is high after being low at the previous edge, `xbit_o` takes `addr_i[6]`. At all other edges `xbit_o` holds its value, whatever the lock state is.
- R9: While `rst_ni` is low, the held address is 0, the lock is clear and `xbit_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Address bus |
| cycle_start_i | input | 1 | Memory cycle start request, sets the lock |
| cycle_end_ni | input | 1 | Cycle-end strobe, active low, clears the lock |
| mem_sel_i | input | 1 | Memory select, enables the bank decode |
| xstb_i | input | 1 | Strobe for capturing address bit 6 |
| x_sel_o | output | 7 | X line select field |
| y_sel_o | output | 6 | Y line select field |
| bank_o | output | 8 | One-hot bank select |
| xbit_o | output | 1 | Edge-captured address bit 6 |

## Verification
When the lock is clear, an address driven before a rising edge appears on the X, Y and bank outputs right after that single edge. A low cycle-end sample takes two edges to show a new address: one edge clears the lock and the next edge loads the bus. The bank outputs respond to `mem_sel_i` with no clock at all. The strobe capture lands one edge after `xstb_i` rises. The bench changes its inputs on the falling edge, lets exactly the number of rising edges its model says are needed go by, and samples on the next falling edge. A full sweep of all 65536 addresses checks the three fields against values computed arithmetically from the driven address.

// File: rtl/addr_hold_pkg.sv
package addr_hold_pkg;
  localparam int unsigned ADDR_W_DEF = 16;
  localparam int unsigned X_W_DEF    = 7;
  localparam int unsigned Y_W_DEF    = 6;
  localparam int unsigned BANK_W_DEF = ADDR_W_DEF - X_W_DEF - Y_W_DEF;
  localparam int unsigned NBANK_DEF  = 1 << BANK_W_DEF;
  localparam int unsigned XBIT_IDX   = 6;

  typedef enum logic {
    LK_OPEN = 1'b0,
    LK_HELD = 1'b1
  } lock_state_e;
endpackage

// File: rtl/addr_lock_ctrl.sv
module addr_lock_ctrl
  import addr_hold_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic end_ni,
  output logic lock_o
);
  lock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!end_ni)      state_d = LK_OPEN;  // end wins over start
    else if (start_i) state_d = LK_HELD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LK_OPEN;
    else         state_q <= state_d;
  end

  assign lock_o = (state_q == LK_HELD);
endmodule

// File: rtl/addr_hold_reg.sv
module addr_hold_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned N    = 1 << SEL_W
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [N-1:0]     bank_o
);
  for (genvar k = 0; k < N; k++) begin : g_bank
    assign bank_o[k] = en_i && (sel_i == SEL_W'(k));
  end
endmodule

// File: rtl/strobe_capture.sv
module strobe_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic d_i,
  output logic q_o
);
  logic stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= 1'b0;
      q_o   <= 1'b0;
    end else begin
      stb_q <= stb_i;
      if (stb_i && !stb_q) q_o <= d_i;
    end
  end
endmodule

// File: rtl/addr_hold_unit.sv
module addr_hold_unit
  import addr_hold_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned X_W    = X_W_DEF,
  parameter int unsigned Y_W    = Y_W_DEF,
  localparam int unsigned BANK_W = ADDR_W - X_W - Y_W,
  localparam int unsigned NBANK  = 1 << BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cycle_start_i,
  input  logic              cycle_end_ni,
  input  logic              mem_sel_i,
  input  logic              xstb_i,
  output logic [X_W-1:0]    x_sel_o,
  output logic [Y_W-1:0]    y_sel_o,
  output logic [NBANK-1:0]  bank_o,
  output logic              xbit_o
);
  logic              lock_q;
  logic [ADDR_W-1:0] held_q;

  addr_lock_ctrl u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cycle_start_i),
    .end_ni  (cycle_end_ni),
    .lock_o  (lock_q)
  );

  // synchronous stand-in for a transparent latch: load every edge while open
  addr_hold_reg #(.W(ADDR_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (!lock_q),
    .d_i    (addr_i),
    .q_o    (held_q)
  );

  bank_decoder #(.SEL_W(BANK_W)) u_bank (
    .en_i   (mem_sel_i),
    .sel_i  (held_q[ADDR_W-1 -: BANK_W]),
    .bank_o (bank_o)
  );

  strobe_capture u_xcap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (xstb_i),
    .d_i    (addr_i[XBIT_IDX]),
    .q_o    (xbit_o)
  );

  assign x_sel_o = held_q[X_W-1:0];
  assign y_sel_o = held_q[X_W +: Y_W];
endmodule

// File: rtl/addr_hold_unit_chk.sv
module addr_hold_unit_chk
  import addr_hold_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [ADDR_W_DEF-1:0] addr_i,
  input logic                  cycle_start_i,
  input logic                  cycle_end_ni,
  input logic                  mem_sel_i,
  input logic                  xstb_i,
  input logic                  lock_q,
  input logic [X_W_DEF-1:0]    x_sel_o,
  input logic [Y_W_DEF-1:0]    y_sel_o,
  input logic [NBANK_DEF-1:0]  bank_o,
  input logic                  xbit_o
);
  assert_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> ({y_sel_o, x_sel_o} == $past(addr_i[X_W_DEF+Y_W_DEF-1:0])));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && cycle_end_ni) |=> ($stable(x_sel_o) && $stable(y_sel_o) && lock_q));

  assert_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_start_i && cycle_end_ni) |=> lock_q);

  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cycle_end_ni |=> !lock_q);

  assert_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_sel_i |-> ($countones(bank_o) == 1));

  assert_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_sel_i |-> (bank_o == '0));

  assert_xcap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xstb_i && !$past(xstb_i)) |=> (xbit_o == $past(addr_i[XBIT_IDX])));

  assert_xkeep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xstb_i && !$past(xstb_i)) |=> $stable(xbit_o));
endmodule

bind addr_hold_unit addr_hold_unit_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .cycle_start_i (cycle_start_i),
  .cycle_end_ni  (cycle_end_ni),
  .mem_sel_i     (mem_sel_i),
  .xstb_i        (xstb_i),
  .lock_q        (lock_q),
  .x_sel_o       (x_sel_o),
  .y_sel_o       (y_sel_o),
  .bank_o        (bank_o),
  .xbit_o        (xbit_o)
);

// File: tb/addr_hold_unit_bench.sv
`timescale 1ns/1ps
module addr_hold_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        cycle_start_i = 1'b0;
  logic        cycle_end_ni = 1'b1;
  logic        mem_sel_i = 1'b1;
  logic        xstb_i = 1'b0;
  logic [6:0]  x_sel_o;
  logic [5:0]  y_sel_o;
  logic [7:0]  bank_o;
  logic        xbit_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  addr_hold_unit u_addr_hold_unit (
    .clk_i, .rst_ni, .addr_i, .cycle_start_i, .cycle_end_ni,
    .mem_sel_i, .xstb_i, .x_sel_o, .y_sel_o, .bank_o, .xbit_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // fields of an expected held address, computed arithmetically
  task automatic chk_addr(input string req, input logic [15:0] a);
    chk({req, " R1 x"}, 32'(x_sel_o), 32'(a % 128));
    chk({req, " R2 y"}, 32'(y_sel_o), 32'((a / 128) % 64));
    chk({req, " R3 bank"}, 32'(bank_o), 32'(1) << (a / 8192));
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    logic [15:0] hold_a;
    repeat (3) @(negedge clk_i);
    // R9: reset state
    chk_addr("R9 reset", 16'h0000);
    chk("R9 xbit", 32'(xbit_o), 0);
    rst_ni = 1'b1;
    step();

    // R5/R1/R2/R3: exhaustive sweep while unlocked
    for (int a = 0; a < 65536; a++) begin
      addr_i = 16'(a);
      step();
      chk_addr("R5 sweep", 16'(a));
    end

    // R4: decode gated off for every bank value
    mem_sel_i = 1'b0;
    for (int b = 0; b < 8; b++) begin
      addr_i = 16'(b << 13) | 16'h0A5A;
      step();
      chk("R4 gated", 32'(bank_o), 0);
    end
    mem_sel_i = 1'b1;
    @(negedge clk_i);
    chk("R3 regated", 32'(bank_o), 32'(1) << 7);

    // R6: lock keeps the address sampled on the start edge
    hold_a = 16'hB3C5;
    addr_i = hold_a;
    cycle_start_i = 1'b1;
    step();
    cycle_start_i = 1'b0;
    chk_addr("R6 start", hold_a);
    for (int i = 0; i < 24; i++) begin
      addr_i = 16'(i * 16'h2F1B) ^ 16'h5AA5;
      step();
      chk_addr("R6 locked", hold_a);
    end

    // R7: end edge clears lock without loading, next edge loads
    addr_i = 16'h1234;
    cycle_end_ni = 1'b0;
    step();
    cycle_end_ni = 1'b1;
    chk_addr("R7 end edge", hold_a);
    step();
    chk_addr("R7 reopen", 16'h1234);

    // R7: end has priority over start
    addr_i = 16'hE001;
    cycle_start_i = 1'b1;
    cycle_end_ni = 1'b0;
    step();
    cycle_start_i = 1'b0;
    cycle_end_ni = 1'b1;
    chk_addr("R7 prio load", 16'hE001);
    addr_i = 16'h7F80;
    step();
    chk_addr("R7 prio open", 16'h7F80);

    // R8: strobe capture of bit 6
    addr_i = 16'h0040;
    xstb_i = 1'b1;
    step();
    chk("R8 rise1", 32'(xbit_o), 1);
    addr_i = 16'h0000;
    step();
    chk("R8 level", 32'(xbit_o), 1);
    xstb_i = 1'b0;
    step();
    chk("R8 low", 32'(xbit_o), 1);
    xstb_i = 1'b1;
    step();
    chk("R8 rise0", 32'(xbit_o), 0);
    xstb_i = 1'b0;

    // R8 while locked: capture still works, fields stay frozen
    addr_i = 16'h4321;
    cycle_start_i = 1'b1;
    step();
    cycle_start_i = 1'b0;
    addr_i = 16'h00C0;
    xstb_i = 1'b1;
    step();
    chk("R8 locked", 32'(xbit_o), 1);
    chk_addr("R6 locked xstb", 16'h4321);
    xstb_i = 1'b0;
    cycle_end_ni = 1'b0;
    step();
    cycle_end_ni = 1'b1;
    step();
    chk_addr("R7 final", 16'h00C0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule